// File: doc/BRIEF.md
# Power Supply Enable Sequencer

This block decides when a power converter is allowed to start and when its two power-good outputs are raised. An enable is formed from a hardware pin (with selectable polarity) and a software bit, according to a 2-bit source selection. Once enabled, the block waits a programmable start delay and then raises a soft-start request. It holds the request while the enable stays true.

When the external ramp logic reports that soft start has finished, each power-good output runs its own turn-on debounce and then asserts. Either output falls on the next clock edge once its condition is lost, with no turn-off debounce. The second output also drops on any of five fault flags: voltage continuity, OR-ing FET disable, AC sense, external flag and over-temperature. A masking mode can make a flag count only when its configured fault action is not "ignore". Dropping the enable at any point returns the block to idle and clears everything.

All times are counted in pulses of a shared tick input. The parameter `UNIT_TICKS` gives the number of tick pulses per millisecond.

Top module: `pwr_enable_seq`

## Requirements
- R1: `src_sel` picks the enable: 2'b00 uses the pin only, 2'b01 uses `sw_on` only (1 = on, 0 = off), 2'b10 needs both the pin and `sw_on`, and 2'b11 is always enabled. An input that the selected mode does not use has no effect.
- R2: The pin is on when `pin_raw` is 1 with `pin_inv` = 0, and when `pin_raw` is 0 with `pin_inv` = 1.
- R3: `dly_sel` sets the start delay: 2'b00 = 0 ms, 2'b01 = 500 ms, 2'b10 = 1000 ms, 2'b11 = 2000 ms. With D = delay × `UNIT_TICKS` and a tick on every cycle, `ss_start` rises D+2 clock edges after the enable becomes true.
- R4: A false enable clears `ss_start`, `pgood1` and `pgood2` on the next edge and returns the block to idle. A later enable restarts the full delay.
- R5: `pg1_db_sel` and `pg2_db_sel` each set the turn-on debounce of their own output: 2'b00 = 350 ms, 2'b01 = 150 ms, 2'b10 = 550 ms, 2'b11 = 0 ms. With T = debounce × `UNIT_TICKS` and a tick on every cycle, the output rises T+1 edges after its condition becomes true. The condition is `ss_start` and `ss_done`, plus no effective fault for `pgood2`.
- R6: When `ss_done` falls, both power-good outputs fall on the next edge. When it returns, the debounce restarts.
- R7: With `flag_mask_mode` = 0, any asserted flag in `flag_raw` drops `pgood2` on the next edge and leaves `pgood1` unchanged. The flag bits are: bit 0 continuity, bit 1 OR-ing FET disable, bit 2 AC sense, bit 3 external flag, bit 4 over-temperature.
- R8: With `flag_mask_mode` = 1, flag i counts only when `flag_act[3i+2:3i]` is not 3'b000.
- R9: The external flag (bit 3) is active when its raw value XOR `ext_flag_inv` is 1.
- R10: `gate_out` equals `orfet_on` XOR `gate_inv`.
- R11: The delay and debounce counters advance only in cycles where `tick` is 1.
- R12: While reset is held, `ss_start`, `pgood1` and `pgood2` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Time-base pulse |
| src_sel | input | 2 | Enable source select |
| sw_on | input | 1 | Software enable bit |
| pin_raw | input | 1 | Hardware enable pin level |
| pin_inv | input | 1 | Enable pin polarity (1 = active low) |
| dly_sel | input | 2 | Start delay code |
| pg1_db_sel | input | 2 | First power-good debounce code |
| pg2_db_sel | input | 2 | Second power-good debounce code |
| ss_done | input | 1 | Soft-start ramp finished |
| flag_raw | input | 5 | Fault flag levels |
| flag_act | input | 15 | Per-flag 3-bit fault action codes |
| flag_mask_mode | input | 1 | 1 = flags with action 000 are ignored |
| ext_flag_inv | input | 1 | External flag polarity (1 = active low) |
| orfet_on | input | 1 | OR-ing FET on request |
| gate_inv | input | 1 | Gate output polarity (1 = active low) |
| ss_start | output | 1 | Soft-start request |
| pgood1 | output | 1 | First power-good output |
| pgood2 | output | 1 | Second power-good output |
| gate_out | output | 1 | OR-ing FET gate drive |

## Verification
On every cycle the assertions check three things: the next-edge clearing after a lost enable, a lost condition or an effective fault; that the delay count freezes without a tick; and that `ss_start` rises only out of the waiting state. Only the directed scenarios can show the exact edge counts for each delay and debounce code, the source-selection and polarity truth tables, the masking by action code, and that the delay starts again from zero after a cancel.

// File: rtl/pes_pkg.sv
package pes_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_RUN  = 2'd2
    } seq_state_e;

    localparam int unsigned NUM_FLAGS    = 5;
    localparam int unsigned ACT_W        = 3;
    localparam int unsigned FLAG_EXT_IDX = 3;
    localparam int unsigned MAX_DELAY_MS = 2000;
    localparam int unsigned MAX_DB_MS    = 550;

    function automatic int unsigned start_delay_ms(input logic [1:0] code);
        case (code)
            2'b00:   return 0;
            2'b01:   return 500;
            2'b10:   return 1000;
            default: return 2000;
        endcase
    endfunction

    function automatic int unsigned pg_debounce_ms(input logic [1:0] code);
        case (code)
            2'b00:   return 350;
            2'b01:   return 150;
            2'b10:   return 550;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/pes_src_sel.sv
module pes_src_sel (
    input  logic [1:0] src_sel,
    input  logic       pin_raw,
    input  logic       pin_inv,
    input  logic       sw_on,
    output logic       en
);
    logic pin_on;

    assign pin_on = pin_raw ^ pin_inv;

    always_comb begin
        case (src_sel)
            2'b00:   en = pin_on;
            2'b01:   en = sw_on;
            2'b10:   en = pin_on & sw_on;
            default: en = 1'b1;
        endcase
    end
endmodule

// File: rtl/pes_fault_merge.sv
module pes_fault_merge
    import pes_pkg::*;
(
    input  logic [NUM_FLAGS-1:0]       flag_raw,
    input  logic [NUM_FLAGS*ACT_W-1:0] flag_act,
    input  logic                       mask_mode,
    input  logic                       ext_inv,
    output logic                       fault_any
);
    logic [NUM_FLAGS-1:0] level;
    logic [NUM_FLAGS-1:0] eff;

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        if (i == FLAG_EXT_IDX) begin : g_pol
            assign level[i] = flag_raw[i] ^ ext_inv;
        end else begin : g_plain
            assign level[i] = flag_raw[i];
        end
        assign eff[i] = level[i] & (~mask_mode | (|flag_act[i*ACT_W +: ACT_W]));
    end

    assign fault_any = |eff;
endmodule

// File: rtl/pes_pg_chan.sv
module pes_pg_chan
    import pes_pkg::*;
#(
    parameter int unsigned UNIT_TICKS = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       cond,
    input  logic [1:0] db_sel,
    output logic       pg
);
    localparam int unsigned CW = $clog2(MAX_DB_MS * UNIT_TICKS + 1);

    typedef struct packed {
        logic          pg;
        logic [CW-1:0] cnt;
    } chan_t;

    chan_t         q, d;
    logic [CW-1:0] tgt;

    assign tgt = CW'(pg_debounce_ms(db_sel) * UNIT_TICKS);

    always_comb begin
        d = q;
        if (!cond) begin
            d.pg  = 1'b0;
            d.cnt = '0;
        end else begin
            d.pg = q.pg | (q.cnt >= tgt);
            if (tick && (q.cnt < tgt)) begin
                d.cnt = q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pg = q.pg;

    p_drop_now_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cond |=> !pg);

    p_hold_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pg && cond) |=> pg);
endmodule

// File: rtl/pwr_enable_seq.sv
module pwr_enable_seq
    import pes_pkg::*;
#(
    parameter int unsigned UNIT_TICKS = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic [1:0]  src_sel,
    input  logic        sw_on,
    input  logic        pin_raw,
    input  logic        pin_inv,
    input  logic [1:0]  dly_sel,
    input  logic [1:0]  pg1_db_sel,
    input  logic [1:0]  pg2_db_sel,
    input  logic        ss_done,
    input  logic [4:0]  flag_raw,
    input  logic [14:0] flag_act,
    input  logic        flag_mask_mode,
    input  logic        ext_flag_inv,
    input  logic        orfet_on,
    input  logic        gate_inv,
    output logic        ss_start,
    output logic        pgood1,
    output logic        pgood2,
    output logic        gate_out
);
    localparam int unsigned DW    = $clog2(MAX_DELAY_MS * UNIT_TICKS + 1);
    localparam int unsigned NUM_PG = 2;

    typedef struct packed {
        seq_state_e    st;
        logic [DW-1:0] cnt;
    } seq_t;

    seq_t              q, d;
    logic              en;
    logic              fault_any;
    logic [DW-1:0]     dly_tgt;
    logic [NUM_PG-1:0] pg_cond;
    logic [NUM_PG-1:0] pg_out;
    logic [1:0]        db_sel [NUM_PG];

    pes_src_sel u_src (
        .src_sel (src_sel),
        .pin_raw (pin_raw),
        .pin_inv (pin_inv),
        .sw_on   (sw_on),
        .en      (en)
    );

    pes_fault_merge u_flt (
        .flag_raw  (flag_raw),
        .flag_act  (flag_act),
        .mask_mode (flag_mask_mode),
        .ext_inv   (ext_flag_inv),
        .fault_any (fault_any)
    );

    assign dly_tgt = DW'(start_delay_ms(dly_sel) * UNIT_TICKS);

    always_comb begin
        d = q;
        case (q.st)
            SEQ_IDLE: begin
                if (en) begin
                    d.st  = SEQ_WAIT;
                    d.cnt = '0;
                end
            end
            SEQ_WAIT: begin
                if (!en) begin
                    d.st = SEQ_IDLE;
                end else if (q.cnt >= dly_tgt) begin
                    d.st = SEQ_RUN;
                end else if (tick) begin
                    d.cnt = q.cnt + DW'(1);
                end
            end
            SEQ_RUN: begin
                if (!en) d.st = SEQ_IDLE;
            end
            default: d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: SEQ_IDLE, cnt: '0};
        else        q <= d;
    end

    assign ss_start   = (q.st == SEQ_RUN);
    assign pg_cond[0] = ss_start & ss_done & en;
    assign pg_cond[1] = pg_cond[0] & ~fault_any;
    assign db_sel[0]  = pg1_db_sel;
    assign db_sel[1]  = pg2_db_sel;

    for (genvar k = 0; k < NUM_PG; k++) begin : g_pg
        pes_pg_chan #(.UNIT_TICKS(UNIT_TICKS)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .cond   (pg_cond[k]),
            .db_sel (db_sel[k]),
            .pg     (pg_out[k])
        );
    end

    assign pgood1   = pg_out[0];
    assign pgood2   = pg_out[1];
    assign gate_out = orfet_on ^ gate_inv;

    p_cancel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (q.st == SEQ_IDLE && !pgood1 && !pgood2));

    p_pg_needs_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pgood1 || pgood2) |-> ss_start);

    p_fault_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_any |=> !pgood2);

    p_start_from_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_start) |-> $past(q.st == SEQ_WAIT));

    p_hold_no_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SEQ_WAIT && en && !tick && q.cnt < dly_tgt) |=> $stable(q.cnt));
endmodule

// File: tb/sim_pwr_enable_seq.sv
module sim_pwr_enable_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic [1:0]  src_sel = 2'b01;
    logic        sw_on = 1'b0;
    logic        pin_raw = 1'b0;
    logic        pin_inv = 1'b0;
    logic [1:0]  dly_sel = 2'b00;
    logic [1:0]  pg1_db_sel = 2'b11;
    logic [1:0]  pg2_db_sel = 2'b11;
    logic        ss_done = 1'b0;
    logic [4:0]  flag_raw = '0;
    logic [14:0] flag_act = '0;
    logic        flag_mask_mode = 1'b0;
    logic        ext_flag_inv = 1'b0;
    logic        orfet_on = 1'b0;
    logic        gate_inv = 1'b0;
    logic        ss_start, pgood1, pgood2, gate_out;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pwr_enable_seq #(.UNIT_TICKS(1)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .src_sel(src_sel), .sw_on(sw_on),
        .pin_raw(pin_raw), .pin_inv(pin_inv), .dly_sel(dly_sel),
        .pg1_db_sel(pg1_db_sel), .pg2_db_sel(pg2_db_sel), .ss_done(ss_done),
        .flag_raw(flag_raw), .flag_act(flag_act), .flag_mask_mode(flag_mask_mode),
        .ext_flag_inv(ext_flag_inv), .orfet_on(orfet_on), .gate_inv(gate_inv),
        .ss_start(ss_start), .pgood1(pgood1), .pgood2(pgood2), .gate_out(gate_out)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic go_idle();
        src_sel = 2'b01; sw_on = 1'b0; pin_raw = 1'b0; pin_inv = 1'b0;
        ss_done = 1'b0; tick = 1'b1; dly_sel = 2'b00;
        step(2);
    endtask

    task automatic t_reset();
        step(3);
        chk("R12", "ss_start in reset", ss_start, 1'b0);
        chk("R12", "pgood1 in reset", pgood1, 1'b0);
        chk("R12", "pgood2 in reset", pgood2, 1'b0);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic t_source();
        src_sel = 2'b00; sw_on = 1'b1; pin_raw = 1'b0;
        step(5);  chk("R1", "pin mode ignores sw", ss_start, 1'b0);
        pin_raw = 1'b1;
        step(1);  chk("R1", "pin mode edge 1", ss_start, 1'b0);
        step(1);  chk("R1", "pin mode edge 2", ss_start, 1'b1);
        go_idle();
        src_sel = 2'b00; pin_inv = 1'b1; pin_raw = 1'b0;
        step(2);  chk("R2", "inverted pin low is on", ss_start, 1'b1);
        pin_raw = 1'b1;
        step(1);  chk("R2", "inverted pin high is off", ss_start, 1'b0);
        go_idle();
        src_sel = 2'b01; pin_raw = 1'b1; sw_on = 1'b0;
        step(5);  chk("R1", "sw mode ignores pin", ss_start, 1'b0);
        sw_on = 1'b1;
        step(2);  chk("R1", "sw mode on", ss_start, 1'b1);
        go_idle();
        src_sel = 2'b10; sw_on = 1'b1; pin_raw = 1'b0;
        step(5);  chk("R1", "both mode needs pin", ss_start, 1'b0);
        pin_raw = 1'b1;
        step(2);  chk("R1", "both mode on", ss_start, 1'b1);
        go_idle();
        src_sel = 2'b11;
        step(2);  chk("R1", "always-on mode", ss_start, 1'b1);
        go_idle();
    endtask

    task automatic t_delay();
        for (int c = 1; c < 4; c++) begin
            int ms;
            ms = (c == 1) ? 500 : (c == 2) ? 1000 : 2000;
            dly_sel = c[1:0]; sw_on = 1'b1;
            step(ms + 1); chk("R3", "just before delay end", ss_start, 1'b0);
            step(1);      chk("R3", "at delay end", ss_start, 1'b1);
            go_idle();
        end
    endtask

    task automatic t_cancel();
        dly_sel = 2'b01; sw_on = 1'b1;
        step(300);
        sw_on = 1'b0;
        step(1);
        sw_on = 1'b1;
        step(501); chk("R4", "delay restarted, not yet", ss_start, 1'b0);
        step(1);   chk("R4", "delay restarted, done", ss_start, 1'b1);
        pg1_db_sel = 2'b11; pg2_db_sel = 2'b11; ss_done = 1'b1;
        step(1);   chk("R5", "zero debounce pg1", pgood1, 1'b1);
                   chk("R5", "zero debounce pg2", pgood2, 1'b1);
        sw_on = 1'b0;
        step(1);   chk("R4", "cancel ss_start", ss_start, 1'b0);
                   chk("R4", "cancel pgood1", pgood1, 1'b0);
                   chk("R4", "cancel pgood2", pgood2, 1'b0);
        go_idle();
    endtask

    task automatic t_debounce();
        pg1_db_sel = 2'b01; pg2_db_sel = 2'b00; sw_on = 1'b1;
        step(2); ss_done = 1'b1;
        step(150); chk("R5", "pg1 150ms early", pgood1, 1'b0);
        step(1);   chk("R5", "pg1 150ms on", pgood1, 1'b1);
                   chk("R5", "pg2 separate", pgood2, 1'b0);
        step(199); chk("R5", "pg2 350ms early", pgood2, 1'b0);
        step(1);   chk("R5", "pg2 350ms on", pgood2, 1'b1);
        go_idle();
        pg1_db_sel = 2'b10; pg2_db_sel = 2'b11; sw_on = 1'b1;
        step(2); ss_done = 1'b1;
        step(1);   chk("R5", "pg2 0ms on", pgood2, 1'b1);
                   chk("R5", "pg1 550ms pending", pgood1, 1'b0);
        step(549); chk("R5", "pg1 550ms early", pgood1, 1'b0);
        step(1);   chk("R5", "pg1 550ms on", pgood1, 1'b1);
        ss_done = 1'b0;
        step(1);   chk("R6", "pg1 drops", pgood1, 1'b0);
                   chk("R6", "pg2 drops", pgood2, 1'b0);
        ss_done = 1'b1;
        step(1);   chk("R6", "pg2 back after 0ms", pgood2, 1'b1);
                   chk("R6", "pg1 debounce restarted", pgood1, 1'b0);
        go_idle();
    endtask

    task automatic t_faults();
        pg1_db_sel = 2'b11; pg2_db_sel = 2'b01; sw_on = 1'b1;
        step(2); ss_done = 1'b1;
        step(151); chk("R5", "pg2 up before faults", pgood2, 1'b1);
        flag_mask_mode = 1'b0; flag_act = '0; flag_raw = 5'b00001;
        step(1);   chk("R7", "flag drops pg2", pgood2, 1'b0);
                   chk("R7", "flag leaves pg1", pgood1, 1'b1);
        flag_raw = '0;
        step(150); chk("R7", "pg2 re-debounce early", pgood2, 1'b0);
        step(1);   chk("R7", "pg2 re-debounced", pgood2, 1'b1);
        flag_mask_mode = 1'b1; flag_raw = 5'b00100;
        step(5);   chk("R8", "action 000 ignored", pgood2, 1'b1);
        flag_act[8:6] = 3'b010;
        step(1);   chk("R8", "action nonzero counts", pgood2, 1'b0);
        flag_raw = '0; flag_act = '0; flag_mask_mode = 1'b0;
        step(151); chk("R8", "pg2 recovered", pgood2, 1'b1);
        ext_flag_inv = 1'b1; flag_raw = 5'b01000;
        step(3);   chk("R9", "inverted ext high inactive", pgood2, 1'b1);
        flag_raw = 5'b00000;
        step(1);   chk("R9", "inverted ext low active", pgood2, 1'b0);
        ext_flag_inv = 1'b0;
        step(151); chk("R9", "pg2 recovered", pgood2, 1'b1);
        go_idle();
    endtask

    task automatic t_gate();
        orfet_on = 1'b1; gate_inv = 1'b0; #1;
        chk("R10", "gate normal on", gate_out, 1'b1);
        gate_inv = 1'b1; #1;
        chk("R10", "gate inverted on", gate_out, 1'b0);
        orfet_on = 1'b0; #1;
        chk("R10", "gate inverted off", gate_out, 1'b1);
        gate_inv = 1'b0; #1;
        chk("R10", "gate normal off", gate_out, 1'b0);
        step(1);
    endtask

    task automatic t_tick();
        dly_sel = 2'b01; tick = 1'b0; sw_on = 1'b1;
        step(800); chk("R11", "delay frozen without tick", ss_start, 1'b0);
        tick = 1'b1;
        step(500); chk("R11", "delay early with tick", ss_start, 1'b0);
        step(1);   chk("R11", "delay done with tick", ss_start, 1'b1);
        pg1_db_sel = 2'b01; tick = 1'b0; ss_done = 1'b1;
        step(300); chk("R11", "debounce frozen without tick", pgood1, 1'b0);
        tick = 1'b1;
        step(150); chk("R11", "debounce early", pgood1, 1'b0);
        step(1);   chk("R11", "debounce done", pgood1, 1'b1);
        go_idle();
    endtask

    initial begin
        t_reset();
        t_source();
        t_delay();
        t_cancel();
        t_debounce();
        t_faults();
        t_gate();
        t_tick();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule